// File: doc/BRIEF.md
# Modular-Exponentiation Engine Control Registers

This block is the register file that software uses to drive a public-key exponentiation engine. It sits on a simple 32-bit register bus that has separate write and read strobes. Through the bus, software sets the address and length of the source buffer that the DMA mover fetches. It also sets the bit lengths of the exponent and the modulus, chooses whether the data memory belongs to the CPU bus or to the engine, and launches jobs. When the engine reports that a job has finished, the block records the event in a status bit. It also produces a level interrupt while that bit is enabled in the mask.

A job starts only when software writes both launch bits of the trigger register together. The block then sends a one-cycle start pulse on the exponentiation line and on the DMA-feed line at the same time. A done pulse from the engine clears the trigger register by itself and sets the completion flag. Software clears that flag by writing a one to it. Reads return data one cycle after the read strobe. Offsets that are not decoded read as zero, and writes to them are ignored.

Top module: `mexp_csr`

## Requirements
- R1: After reset, every register reads zero except the command register, which reads 0x100. The memory-ownership output is 1 (CPU owns the memory), and the start outputs and the interrupt are 0.
- R2: A write to offset 0x000 with bits 1:0 = 2'b11 stores 3 in the trigger register. Both start outputs are then high for exactly the one cycle that follows the write.
- R3: A write to offset 0x000 with only one of bits 1:0 set stores that value and produces no start pulse.
- R4: An engine done pulse clears the trigger register to 0 and sets status bit 1 (offset 0x3FC).
- R5: A write of 0 to the trigger register clears it and produces no start pulse.
- R6: Command register (offset 0x048): bit 8 drives memory ownership (1 = CPU bus, 0 = engine) and bits 5:4 drive the SRAM mode output (2'b11 = exponentiation mode). All other bits read as zero.
- R7: The source base (0x04C), source length (0x050) and key length (0x058) registers hold all 32 bits. The exponent bit-length output equals key-length bits 31:16, and the modulus bit-length output equals bits 15:0.
- R8: Writing 1 to status bit 1 clears it. Writing 0 to it leaves it unchanged.
- R9: When a done pulse and a write-one-to-clear of status bit 1 occur in the same cycle, the bit ends up set.
- R10: The interrupt output is high exactly while status bit 1 and mask bit 1 (offset 0x3F8) are both 1. All other mask bits read as zero.
- R11: Reads from any offset other than the seven mapped word offsets, including misaligned ones, return zero. Writes to such offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| eng_start_exp | output | 1 | Start pulse to the exponentiation datapath |
| eng_start_feed | output | 1 | Start pulse to the DMA feed |
| eng_mem_cpu | output | 1 | 1 = data memory owned by the CPU bus |
| eng_sram_mode | output | 2 | SRAM layout mode select |
| eng_src_base | output | 32 | DMA source base address |
| eng_src_len | output | 32 | DMA source length |
| eng_exp_bits | output | 16 | Exponent bit length |
| eng_mod_bits | output | 16 | Modulus bit length |
| eng_done | input | 1 | Job-finished pulse from the engine |
| irq | output | 1 | Level interrupt |

## Verification
Every register and output updates at the clock edge that samples the strobe or the done pulse. The start pulses, the ownership and length outputs, the trigger value and the interrupt can therefore be seen at the falling edge that follows that edge. Read data arrives one edge after the read strobe and is sampled at that same falling edge. The bench drives every input on a falling edge and checks at the next falling edge, one rising edge later. It checks the absence of a start pulse in the cycle right after the write. The unmapped-offset sweep covers all 1024 word offsets and reads each one back.

// File: rtl/mexp_csr_pkg.sv
package mexp_csr_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int NREG     = 7;
  localparam int IX_TRIG  = 0;
  localparam int IX_CMD   = 1;
  localparam int IX_SRC   = 2;
  localparam int IX_LEN   = 3;
  localparam int IX_KEY   = 4;
  localparam int IX_MSK   = 5;
  localparam int IX_STS   = 6;
  localparam int DONE_BIT = 1;
  localparam int OWN_BIT  = 8;
  localparam int MODE_LO  = 4;

  function automatic logic [ADDR_W-1:0] reg_off(input int ix);
    case (ix)
      IX_TRIG: return 12'h000;
      IX_CMD:  return 12'h048;
      IX_SRC:  return 12'h04C;
      IX_LEN:  return 12'h050;
      IX_KEY:  return 12'h058;
      IX_MSK:  return 12'h3F8;
      default: return 12'h3FC;
    endcase
  endfunction

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    for (int i = 0; i < NREG; i++)
      if (a == reg_off(i)) return 1'b1;
    return 1'b0;
  endfunction
endpackage

// File: rtl/mexp_csr_dec.sv
module mexp_csr_dec
  import mexp_csr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0]   addr,
  output logic [NREG-1:0] sel
);
  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign sel[g] = (addr == AW'(reg_off(g)));
  end
endmodule

// File: rtl/mexp_csr_trig.sv
module mexp_csr_trig (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [1:0] wbits,
  input  logic       done,
  output logic [1:0] trig_q,
  output logic       start_q
);
  logic [1:0] trig_d;
  logic       trig_en;
  logic       start_d;

  always_comb begin
    trig_d  = trig_q;
    trig_en = done | wr_hit;
    start_d = wr_hit & (&wbits);
    if (done)        trig_d = 2'b00;
    else if (wr_hit) trig_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 2'b00;
      start_q <= 1'b0;
    end else begin
      if (trig_en) trig_q <= trig_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/mexp_csr_irq.sv
module mexp_csr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic msk_wr,
  input  logic sts_wr,
  input  logic wbit,
  input  logic done,
  output logic msk_q,
  output logic sts_q,
  output logic irq
);
  logic sts_d;
  logic sts_en;

  always_comb begin
    sts_d  = sts_q;
    sts_en = done | sts_wr;
    if (done)                sts_d = 1'b1;
    else if (sts_wr && wbit) sts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      if (msk_wr) msk_q <= wbit;
      if (sts_en) sts_q <= sts_d;
    end
  end

  assign irq = sts_q & msk_q;
endmodule

// File: rtl/mexp_csr.sv
module mexp_csr
  import mexp_csr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            eng_start_exp,
  output logic            eng_start_feed,
  output logic            eng_mem_cpu,
  output logic [1:0]      eng_sram_mode,
  output logic [DW-1:0]   eng_src_base,
  output logic [DW-1:0]   eng_src_len,
  output logic [DW/2-1:0] eng_exp_bits,
  output logic [DW/2-1:0] eng_mod_bits,
  input  logic            eng_done,
  output logic            irq
);
  localparam int HW = DW / 2;

  logic [1:0]      rst_pipe;
  logic            rst_n_s;
  logic [NREG-1:0] sel;
  logic [NREG-1:0] wsel;
  logic [1:0]      trig_q;
  logic            start_q;
  logic            msk_q;
  logic            sts_q;
  logic            own_q, own_d;
  logic [1:0]      mode_q, mode_d;
  logic [DW-1:0]   src_q, src_d;
  logic [DW-1:0]   len_q, len_d;
  logic [DW-1:0]   key_q, key_d;
  logic            cfg_en;
  logic [DW-1:0]   rd_mux;
  logic [DW-1:0]   rdata_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  mexp_csr_dec #(.AW(AW)) u_dec (.addr(bus_addr), .sel(sel));
  assign wsel = sel & {NREG{bus_wr}};

  mexp_csr_trig u_trig (
    .clk(clk), .rst_n(rst_n_s), .wr_hit(wsel[IX_TRIG]),
    .wbits(bus_wdata[1:0]), .done(eng_done),
    .trig_q(trig_q), .start_q(start_q)
  );

  mexp_csr_irq u_irq (
    .clk(clk), .rst_n(rst_n_s), .msk_wr(wsel[IX_MSK]), .sts_wr(wsel[IX_STS]),
    .wbit(bus_wdata[DONE_BIT]), .done(eng_done),
    .msk_q(msk_q), .sts_q(sts_q), .irq(irq)
  );

  always_comb begin
    own_d  = own_q;
    mode_d = mode_q;
    src_d  = src_q;
    len_d  = len_q;
    key_d  = key_q;
    cfg_en = |{wsel[IX_CMD], wsel[IX_SRC], wsel[IX_LEN], wsel[IX_KEY]};
    if (wsel[IX_CMD]) begin
      own_d  = bus_wdata[OWN_BIT];
      mode_d = bus_wdata[MODE_LO+1:MODE_LO];
    end
    if (wsel[IX_SRC]) src_d = bus_wdata;
    if (wsel[IX_LEN]) len_d = bus_wdata;
    if (wsel[IX_KEY]) key_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      own_q  <= 1'b1;
      mode_q <= 2'b00;
      src_q  <= '0;
      len_q  <= '0;
      key_q  <= '0;
    end else if (cfg_en) begin
      own_q  <= own_d;
      mode_q <= mode_d;
      src_q  <= src_d;
      len_q  <= len_d;
      key_q  <= key_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel[IX_TRIG]) rd_mux[1:0] = trig_q;
    if (sel[IX_CMD]) begin
      rd_mux[OWN_BIT]             = own_q;
      rd_mux[MODE_LO+1:MODE_LO]   = mode_q;
    end
    if (sel[IX_SRC]) rd_mux = src_q;
    if (sel[IX_LEN]) rd_mux = len_q;
    if (sel[IX_KEY]) rd_mux = key_q;
    if (sel[IX_MSK]) rd_mux[DONE_BIT] = msk_q;
    if (sel[IX_STS]) rd_mux[DONE_BIT] = sts_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata      = rdata_q;
  assign eng_start_exp  = start_q;
  assign eng_start_feed = start_q;
  assign eng_mem_cpu    = own_q;
  assign eng_sram_mode  = mode_q;
  assign eng_src_base   = src_q;
  assign eng_src_len    = len_q;
  assign eng_exp_bits   = key_q[DW-1:HW];
  assign eng_mod_bits   = key_q[HW-1:0];
endmodule

// File: rtl/mexp_csr_chk.sv
module mexp_csr_chk
  import mexp_csr_pkg::*;
(
  input logic              clk,
  input logic              rst_n_s,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              eng_done,
  input logic              eng_start_exp,
  input logic              eng_mem_cpu,
  input logic [DATA_W-1:0] eng_src_base,
  input logic [DATA_W-1:0] eng_src_len,
  input logic [15:0]       eng_mod_bits,
  input logic [1:0]        trig_q,
  input logic              sts_q
);
  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(eng_start_exp) |-> $past(bus_wr && bus_addr == 12'h000 && bus_wdata[1:0] == 2'b11));

  // R4
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    eng_done |=> (trig_q == 2'b00) && sts_q);

  // R5
  trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_addr == 12'h000 && bus_wdata[1:0] == 2'b00) |=> (trig_q == 2'b00) && !eng_start_exp);

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!eng_done && bus_wr && bus_addr == 12'h3FC && bus_wdata[DONE_BIT]) |=> !sts_q);

  // R9
  set_prio_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (eng_done && bus_wr && bus_addr == 12'h3FC) |=> sts_q);

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && !is_mapped(bus_addr) && !eng_done) |=>
      $stable(eng_src_base) && $stable(eng_src_len) && $stable(eng_mod_bits)
      && $stable(eng_mem_cpu) && $stable(trig_q) && $stable(sts_q));
endmodule

bind mexp_csr mexp_csr_chk u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .eng_done(eng_done), .eng_start_exp(eng_start_exp),
  .eng_mem_cpu(eng_mem_cpu), .eng_src_base(eng_src_base), .eng_src_len(eng_src_len),
  .eng_mod_bits(eng_mod_bits), .trig_q(trig_q), .sts_q(sts_q)
);

// File: tb/mexp_csr_bench.sv
module mexp_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start_exp, eng_start_feed, eng_mem_cpu, irq;
  logic [1:0]  eng_sram_mode;
  logic [31:0] eng_src_base, eng_src_len;
  logic [15:0] eng_exp_bits, eng_mod_bits;
  logic        eng_done = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  mexp_csr u_mexp_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start_exp(eng_start_exp), .eng_start_feed(eng_start_feed),
    .eng_mem_cpu(eng_mem_cpu), .eng_sram_mode(eng_sram_mode),
    .eng_src_base(eng_src_base), .eng_src_len(eng_src_len),
    .eng_exp_bits(eng_exp_bits), .eng_mod_bits(eng_mod_bits),
    .eng_done(eng_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  function automatic bit mapped(input logic [11:0] a);
    return a == 12'h000 || a == 12'h048 || a == 12'h04C || a == 12'h050 ||
           a == 12'h058 || a == 12'h3F8 || a == 12'h3FC;
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] e_src, e_len, e_key, e_cmd;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 own", {31'b0, eng_mem_cpu}, 32'h1);
    chk("R1 start", {30'b0, eng_start_exp, eng_start_feed}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(12'h000, v); chk("R1 trig", v, 32'h0);
    rd(12'h048, v); chk("R1 cmd", v, 32'h100);
    rd(12'h04C, v); chk("R1 src", v, 32'h0);
    rd(12'h050, v); chk("R1 len", v, 32'h0);
    rd(12'h058, v); chk("R1 key", v, 32'h0);
    rd(12'h3F8, v); chk("R1 msk", v, 32'h0);
    rd(12'h3FC, v); chk("R1 sts", v, 32'h0);

    // R7 data registers and key split
    for (int i = 0; i < 6; i++) begin
      e_src = 32'h9E3779B9 * (i + 1);
      e_len = ~e_src ^ (32'h1 << (i * 5));
      e_key = {16'(i * 1031 + 3), 16'(4096 - i * 517)};
      wr(12'h04C, e_src);
      wr(12'h050, e_len);
      wr(12'h058, e_key);
      chk("R7 base out", eng_src_base, e_src);
      chk("R7 len out", eng_src_len, e_len);
      chk("R7 exp bits", {16'b0, eng_exp_bits}, {16'b0, e_key[31:16]});
      chk("R7 mod bits", {16'b0, eng_mod_bits}, {16'b0, e_key[15:0]});
      rd(12'h04C, v); chk("R7 base rd", v, e_src);
      rd(12'h050, v); chk("R7 len rd", v, e_len);
      rd(12'h058, v); chk("R7 key rd", v, e_key);
    end

    // R6 command field sweep with junk in unused bits
    for (int m = 0; m < 8; m++) begin
      e_cmd = (32'(m >> 2) << 8) | (32'(m & 3) << 4);
      wr(12'h048, ~32'h130 | e_cmd);
      chk("R6 own", {31'b0, eng_mem_cpu}, 32'(m >> 2));
      chk("R6 mode", {30'b0, eng_sram_mode}, 32'(m & 3));
      rd(12'h048, v); chk("R6 read", v, e_cmd);
    end
    e_cmd = 32'h30;
    wr(12'h048, e_cmd);

    // R2 R3 R5 trigger values
    for (int w = 0; w < 4; w++) begin
      wr(12'h000, 32'hFFFF_FFF0 | 32'(w));
      chk(w == 3 ? "R2 start exp" : "R3 no start exp", {31'b0, eng_start_exp}, 32'(w == 3));
      chk(w == 3 ? "R2 start feed" : "R3 no start feed", {31'b0, eng_start_feed}, 32'(w == 3));
      @(negedge clk);
      chk("R2 pulse width", {30'b0, eng_start_exp, eng_start_feed}, 32'h0);
      rd(12'h000, v); chk(w == 3 ? "R2 trig rd" : "R3 trig rd", v, 32'(w));
      wr(12'h000, 32'h0);
      chk("R5 no start", {31'b0, eng_start_exp}, 32'h0);
      rd(12'h000, v); chk("R5 trig clear", v, 32'h0);
    end

    // R4 R10 done with mask enabled
    wr(12'h3F8, 32'hFFFF_FFFF);
    rd(12'h3F8, v); chk("R10 mask rd", v, 32'h2);
    wr(12'h000, 32'h3);
    chk("R10 irq idle", {31'b0, irq}, 32'h0);
    pulse_done();
    chk("R10 irq set", {31'b0, irq}, 32'h1);
    rd(12'h000, v); chk("R4 trig cleared", v, 32'h0);
    rd(12'h3FC, v); chk("R4 status set", v, 32'h2);

    // R8 write-one-to-clear
    wr(12'h3FC, 32'hFFFF_FFFD);
    rd(12'h3FC, v); chk("R8 zero write keeps", v, 32'h2);
    chk("R8 irq kept", {31'b0, irq}, 32'h1);
    wr(12'h3FC, 32'h2);
    rd(12'h3FC, v); chk("R8 one clears", v, 32'h0);
    chk("R10 irq drop", {31'b0, irq}, 32'h0);

    // R10 mask gating
    wr(12'h3F8, 32'h0);
    pulse_done();
    chk("R10 masked", {31'b0, irq}, 32'h0);
    rd(12'h3FC, v); chk("R10 status underneath", v, 32'h2);
    wr(12'h3F8, 32'h2);
    chk("R10 unmask", {31'b0, irq}, 32'h1);
    wr(12'h3FC, 32'h2);

    // R9 done and clear in the same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h3FC; bus_wdata = 32'h2; eng_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; eng_done = 1'b0;
    rd(12'h3FC, v); chk("R9 set wins", v, 32'h2);
    wr(12'h3FC, 32'h2);

    // R11 unmapped sweep over all word offsets plus misaligned offsets
    for (int a = 0; a < 1024; a++) begin
      if (!mapped(12'(a * 4))) begin
        wr(12'(a * 4), 32'hFFFF_FFFF);
        rd(12'(a * 4), v); chk("R11 unmapped read", v, 32'h0);
      end
    end
    wr(12'h049, 32'hFFFF_FFFF);
    wr(12'h001, 32'h3);
    chk("R11 misaligned no start", {31'b0, eng_start_exp}, 32'h0);
    rd(12'h04E, v); chk("R11 misaligned read", v, 32'h0);
    rd(12'h000, v); chk("R11 trig intact", v, 32'h0);
    rd(12'h048, v); chk("R11 cmd intact", v, e_cmd);
    rd(12'h04C, v); chk("R11 src intact", v, e_src);
    rd(12'h050, v); chk("R11 len intact", v, e_len);
    rd(12'h058, v); chk("R11 key intact", v, e_key);
    rd(12'h3F8, v); chk("R11 msk intact", v, 32'h2);
    rd(12'h3FC, v); chk("R11 sts intact", v, 32'h0);
    chk("R11 irq intact", {31'b0, irq}, 32'h0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule